// File: doc/BRIEF.md
# Multi-Pin Sample Serializer

This block turns one receiver channel's parallel I and Q samples into framed serial streams for an external host. A programmable divider sets the length of one serial bit time in system clocks. Frames of a programmable number of bit times follow one another back to back. A one-bit-time frame strobe marks the start of each frame. After a programmable 0 to 3 bit-time offset, the held sample leaves most significant bit first. Each component uses either two or four output pins. The Q stream may come from the neighbouring channel's Q input instead of the channel's own.

Samples may arrive at any time. Only the most recent one is kept, and it is taken in at the next frame start. All configuration inputs are sampled at frame starts only, so a frame already under way always completes with the settings it began with. A frame length of zero stops the block and leaves all outputs low.

Top module: `sample_serializer`

## Requirements
- R1: A bit time lasts `cfg_div_i`+1 system clocks (field 0 to 15). Within each bit time `sclk_o` is low for the first floor((`cfg_div_i`+1)/2) clocks and high for the rest. At a divide of 1 it therefore stays high.
- R2: A frame lasts `cfg_intv_i` bit times. `fsync_o` is high during the first bit time of every frame and low in all other bit times.
- R3: During reset, and from the first frame start at which `cfg_intv_i` is 0, `sclk_o`, `fsync_o` and `data_o` are all held at 0.
- R4: The first data group appears in bit time `cfg_dly_i` of the frame, where the strobe bit time is number 0. Pins carry 0 before that.
- R5: Wide mode (`cfg_wide_i`=1) carries I on `data_o[3:0]` and Q on `data_o[7:4]`. Narrow mode carries I on `data_o[1:0]` and Q on `data_o[5:4]`, and `data_o[3:2]` and `data_o[7:6]` stay 0. In each bit time the next N bits go out together, where N is the number of lanes per component. The earliest of those bits goes on the highest lane of the component.
- R6: The sample length is L = min(`cfg_bits_i`+1, 18), and the low L bits of the input are sent. The last group is padded with zeros at its low end. Pins carry 0 from the end of the sample until the next frame.
- R7: When `cfg_alt_i`=1 at a frame start, the Q lanes of that frame carry `samp_q_nb_i` instead of `samp_q_i`.
- R8: A sample presented with `samp_vld_i` goes out in the first frame that starts after the clock edge on which it was accepted. A frame that starts with no sample pending sends all zeros.
- R9: If a second sample is accepted before the next frame start, it replaces the first one. Only the later sample is sent.
- R10: Configuration inputs affect only frames that start after they change. A change made during a frame leaves that frame's timing and data unchanged.
- R11: `data_o` changes only on the first system clock of a bit time, which is the falling edge of `sclk_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_vld_i | input | 1 | A new sample is present on the sample inputs |
| samp_i_i | input | 18 | In-phase sample |
| samp_q_i | input | 18 | Quadrature sample of this channel |
| samp_q_nb_i | input | 18 | Quadrature sample of the neighbouring channel |
| cfg_div_i | input | 4 | Bit-time length in system clocks, minus one |
| cfg_bits_i | input | 5 | Sample length in bits, minus one |
| cfg_intv_i | input | 7 | Frame length in bit times (0 stops the block) |
| cfg_dly_i | input | 2 | Bit times from frame strobe to first data group |
| cfg_wide_i | input | 1 | 1: four lanes per component, 0: two lanes |
| cfg_alt_i | input | 1 | 1: Q lanes carry the neighbour's Q sample |
| sclk_o | output | 1 | Serial bit clock |
| fsync_o | output | 1 | Frame strobe, one bit time long |
| data_o | output | 8 | Serial lanes: I on the low half, Q on the high half |

## Verification
The bench builds the block with its defaults of 18-bit samples and four lanes per component. This makes full-length samples reachable in both the 4+4 and 2+2 pin layouts. It also makes reachable the bit-count values that exceed the sample width and must clamp to 18, and sample lengths that leave a partly padded last group. Directed frames cover the slowest divide (16) and the fastest divide (1). They also cover a one-bit sample, both delay extremes, a frame with no pending sample, and a double sample that overwrites the first. Random frames then change every setting in the middle of each frame while the bench checks that frame against its own, unchanged settings.

// File: rtl/sser_pkg.sv
// Shared field widths and the configuration record of the serializer.
// Assumes field sizes are fixed by the register layout the block serves.
package sser_pkg;
    localparam int DIV_W  = 4;
    localparam int BITS_W = 5;
    localparam int INTV_W = 7;
    localparam int DLY_W  = 2;

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [BITS_W-1:0] bits;
        logic [INTV_W-1:0] intv;
        logic [DLY_W-1:0]  dly;
        logic              wide;
        logic              alt;
    } sser_cfg_t;
endpackage

// File: rtl/sser_timing.sv
// Bit-time divider, frame counter and configuration snapshot.
// Produces the serial clock, frame strobe, data window and shift strobe.
// Assumes the configuration record may change on any clock; it is only
// sampled on a frame boundary (every clock while stopped).
module sser_timing
    import sser_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  sser_cfg_t         cfg_in,
    output sser_cfg_t         cur_cfg,
    output logic              active,
    output logic              boundary,
    output logic [DIV_W-1:0]  phase,
    output logic [INTV_W-1:0] bitcnt,
    output logic              shift_en,
    output logic              data_en,
    output logic              sclk,
    output logic              fsync
);
    localparam int HALF_W = DIV_W + 1;

    logic bit_end;
    logic [HALF_W-1:0] half_pt;

    // End of the current bit time and of the current frame.
    always_comb begin
        bit_end  = (phase == cur_cfg.div);
        boundary = !active || (bit_end && (bitcnt == cur_cfg.intv - INTV_W'(1)));
    end

    // Phase and bit counters, snapshot of the configuration at frame starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            phase   <= '0;
            bitcnt  <= '0;
            cur_cfg <= '0;
        end else if (boundary) begin
            active  <= (cfg_in.intv != '0);
            cur_cfg <= cfg_in;
            phase   <= '0;
            bitcnt  <= '0;
        end else if (bit_end) begin
            phase   <= '0;
            bitcnt  <= bitcnt + INTV_W'(1);
        end else begin
            phase   <= phase + DIV_W'(1);
        end
    end

    // Decoded output timing from the counters.
    always_comb begin
        half_pt  = (HALF_W'(cur_cfg.div) + HALF_W'(1)) >> 1;
        sclk     = active && (HALF_W'(phase) >= half_pt);
        fsync    = active && (bitcnt == '0);
        data_en  = active && (bitcnt >= INTV_W'(cur_cfg.dly));
        shift_en = data_en && bit_end;
    end

    // A bit time advances one phase per clock until its last clock.
    assert_phase_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !bit_end && !boundary) |=> (phase == $past(phase) + DIV_W'(1)));

    // The last bit time of a frame is followed by a strobe bit time.
    assert_frame_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active && bit_end && (bitcnt == cur_cfg.intv - INTV_W'(1)) && (cfg_in.intv != '0))
        |=> fsync);

    // Starting with a zero frame length silences the clock and strobe.
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary && (cfg_in.intv == '0)) |=> (!fsync && !sclk));

    // The configuration in use never moves inside a frame.
    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(cur_cfg));
endmodule

// File: rtl/sser_lane_shift.sv
// Shift register for one component (I or Q). On load it left-justifies the
// low `len` bits of the sample; each shift moves out one group of lanes.
// Assumes len is between 1 and SAMPLE_W.
module sser_lane_shift #(
    parameter int SAMPLE_W = 18,
    parameter int LANES    = 4,
    parameter int LEN_W    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [SAMPLE_W-1:0] load_val,
    input  logic [LEN_W-1:0]    len,
    input  logic                shift,
    input  logic                wide,
    input  logic                en,
    output logic [LANES-1:0]    lanes
);
    localparam int NARROW = LANES / 2;
    localparam int SHW    = ((SAMPLE_W + LANES - 1) / LANES) * LANES;

    logic [SHW-1:0] sh;
    logic [SHW-1:0] aligned;

    // Left-justify the active bits; higher input bits fall off the top.
    always_comb begin
        aligned = SHW'(load_val) << (SHW - int'(len));
    end

    // Load at frame start, otherwise shift one group per bit time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh <= '0;
        end else if (load) begin
            sh <= aligned;
        end else if (shift) begin
            sh <= wide ? (sh << LANES) : (sh << NARROW);
        end
    end

    // Lane k takes the k-th bit of the top group, so the top lane leads.
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        if (k < NARROW) begin : g_both
            assign lanes[k] = en && (wide ? sh[SHW-LANES+k] : sh[SHW-NARROW+k]);
        end else begin : g_wide_only
            assign lanes[k] = en && wide && sh[SHW-LANES+k];
        end
    end

    // Once drained, the register only ever shifts in zero padding.
    assert_zero_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load && (sh == '0)) |=> (sh == '0));
endmodule

// File: rtl/sample_serializer.sv
// Top level: holds the latest sample, hands it to the I and Q shifters at
// each frame start and assembles the lane outputs. Assumes LANES is even.
module sample_serializer
    import sser_pkg::*;
#(
    parameter int SAMPLE_W = 18,
    parameter int LANES    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 samp_vld_i,
    input  logic [SAMPLE_W-1:0]  samp_i_i,
    input  logic [SAMPLE_W-1:0]  samp_q_i,
    input  logic [SAMPLE_W-1:0]  samp_q_nb_i,
    input  logic [DIV_W-1:0]     cfg_div_i,
    input  logic [BITS_W-1:0]    cfg_bits_i,
    input  logic [INTV_W-1:0]    cfg_intv_i,
    input  logic [DLY_W-1:0]     cfg_dly_i,
    input  logic                 cfg_wide_i,
    input  logic                 cfg_alt_i,
    output logic                 sclk_o,
    output logic                 fsync_o,
    output logic [2*LANES-1:0]   data_o
);
    localparam int LEN_W = $clog2(SAMPLE_W + 1);

    sser_cfg_t         cfg_in, cur_cfg;
    logic              active, boundary, shift_en, data_en, start, load;
    logic [DIV_W-1:0]  phase;
    logic [INTV_W-1:0] bitcnt;
    logic [SAMPLE_W-1:0] hold_i, hold_q, hold_qn;
    logic              pend;
    logic [LEN_W-1:0]  eff_len;
    logic [SAMPLE_W-1:0] comp_val [2];

    // Gather the configuration pins into one record.
    always_comb begin
        cfg_in = '{div: cfg_div_i, bits: cfg_bits_i, intv: cfg_intv_i,
                   dly: cfg_dly_i, wide: cfg_wide_i, alt: cfg_alt_i};
    end

    sser_timing u_timing (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_in   (cfg_in),
        .cur_cfg  (cur_cfg),
        .active   (active),
        .boundary (boundary),
        .phase    (phase),
        .bitcnt   (bitcnt),
        .shift_en (shift_en),
        .data_en  (data_en),
        .sclk     (sclk_o),
        .fsync    (fsync_o)
    );

    // A real frame starts here; sample length is clamped to the port width.
    always_comb begin
        start = boundary && (cfg_intv_i != '0);
        load  = boundary;
        if (cfg_bits_i >= BITS_W'(SAMPLE_W - 1)) eff_len = LEN_W'(SAMPLE_W);
        else                                     eff_len = LEN_W'(cfg_bits_i) + LEN_W'(1);
    end

    // Keep the newest sample until a frame start consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= 1'b0;
            hold_i  <= '0;
            hold_q  <= '0;
            hold_qn <= '0;
        end else if (samp_vld_i) begin
            pend    <= 1'b1;
            hold_i  <= samp_i_i;
            hold_q  <= samp_q_i;
            hold_qn <= samp_q_nb_i;
        end else if (start) begin
            pend    <= 1'b0;
        end
    end

    // Values handed to the shifters: zeros when nothing is pending.
    always_comb begin
        comp_val[0] = (start && pend) ? hold_i : '0;
        comp_val[1] = (start && pend) ? (cfg_alt_i ? hold_qn : hold_q) : '0;
    end

    for (genvar c = 0; c < 2; c++) begin : g_comp
        sser_lane_shift #(
            .SAMPLE_W (SAMPLE_W),
            .LANES    (LANES),
            .LEN_W    (LEN_W)
        ) u_shift (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load),
            .load_val (comp_val[c]),
            .len      (eff_len),
            .shift    (shift_en),
            .wide     (cur_cfg.wide),
            .en       (data_en),
            .lanes    (data_o[c*LANES +: LANES])
        );
    end

    // Lanes hold their value for a whole bit time.
    assert_data_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (active && (phase != '0)) |-> $stable(data_o));

    // A frame start with no new arrival uses up the pending sample.
    assert_pend_used_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !samp_vld_i) |=> !pend);

    // Every arrival leaves a sample pending for the next frame.
    assert_arrival_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        samp_vld_i |=> pend);

    // Before the delay has elapsed no lane is driven.
    assert_pre_delay_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bitcnt < INTV_W'(cur_cfg.dly)) |-> (data_o == '0));
endmodule

// File: tb/sample_serializer_tb_top.sv
`timescale 1ns/1ps
module sample_serializer_tb_top;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst_n;
    logic        vld;
    logic [17:0] si, sq, sqn;
    logic [3:0]  c_div;
    logic [4:0]  c_bits;
    logic [6:0]  c_intv;
    logic [1:0]  c_dly;
    logic        c_wide, c_alt;
    logic        sclk, fsync;
    logic [7:0]  data;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        int div, bits, intv, dly;
        bit wide, alt, has, dbl;
        logic [17:0] a_i, a_q, a_qn, b_i, b_q, b_qn;
    } plan_t;

    sample_serializer dut_i (
        .clk(clk), .rst_n(rst_n), .samp_vld_i(vld), .samp_i_i(si),
        .samp_q_i(sq), .samp_q_nb_i(sqn), .cfg_div_i(c_div),
        .cfg_bits_i(c_bits), .cfg_intv_i(c_intv), .cfg_dly_i(c_dly),
        .cfg_wide_i(c_wide), .cfg_alt_i(c_alt), .sclk_o(sclk),
        .fsync_o(fsync), .data_o(data)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Bit sent on lane k in group g: j-th bit of the MSB-first, zero-padded stream.
    function automatic logic exp_bit(logic [17:0] s, int len, int n, int g, int k);
        int j = g * n + (n - 1 - k);
        if (j < len) return s[len - 1 - j];
        return 1'b0;
    endfunction

    function automatic logic [7:0] exp_pins(plan_t p, int b);
        logic [7:0] r = '0;
        int len = (p.bits + 1 > 18) ? 18 : p.bits + 1;
        int n = p.wide ? 4 : 2;
        logic [17:0] ei = p.dbl ? p.b_i : p.a_i;
        logic [17:0] eq = p.dbl ? (p.alt ? p.b_qn : p.b_q) : (p.alt ? p.a_qn : p.a_q);
        if (!p.has || b < p.dly) return r;
        for (int k = 0; k < n; k++) begin
            r[k]     = exp_bit(ei, len, n, b - p.dly, k);
            r[4 + k] = exp_bit(eq, len, n, b - p.dly, k);
        end
        return r;
    endfunction

    task automatic apply_cfg(plan_t p);
        c_div = 4'(p.div); c_bits = 5'(p.bits); c_intv = 7'(p.intv);
        c_dly = 2'(p.dly); c_wide = p.wide; c_alt = p.alt;
    endtask

    // Wait for the next frame strobe, check the whole frame against cur,
    // and meanwhile present the next frame's settings and samples.
    task automatic frame_check(plan_t cur, plan_t nx, string tag);
        int d = cur.div + 1;
        bit prev = 1'b0;
        bit ok_s = 1'b1, ok_f = 1'b1, ok_d = 1'b1;
        int as_ = 0, es = 0, af = 0, ef = 0, ad = 0, ed = 0;
        int guard = 0;
        forever begin
            @(negedge clk);
            if (fsync && !prev) break;
            prev = fsync;
            guard++;
            if (guard > 5000) begin
                chk(1'b0, {tag, " no frame strobe"}, 0, 1);
                return;
            end
        end
        for (int c = 0; c < cur.intv * d; c++) begin
            int b = c / d;
            int p = c % d;
            logic [7:0] e;
            if (c > 0) @(negedge clk);
            e = exp_pins(cur, b);
            if (ok_s && sclk !== (p >= d / 2)) begin ok_s = 0; as_ = sclk; es = (p >= d / 2); end
            if (ok_f && fsync !== (b == 0))    begin ok_f = 0; af = fsync; ef = (b == 0); end
            if (ok_d && data !== e)            begin ok_d = 0; ad = data; ed = e; end
            if (c == 0) begin
                apply_cfg(nx);
                if (nx.has) begin vld = 1'b1; si = nx.a_i; sq = nx.a_q; sqn = nx.a_qn; end
            end else if (c == 1) begin
                if (nx.has && nx.dbl) begin si = nx.b_i; sq = nx.b_q; sqn = nx.b_qn; end
                else vld = 1'b0;
            end else if (c == 2) begin
                vld = 1'b0;
            end
        end
        vld = 1'b0;
        chk(ok_s, {tag, " R1 sclk"}, as_, es);
        chk(ok_f, {tag, " R2 fsync"}, af, ef);
        chk(ok_d, {tag, " data R10"}, ad, ed);
    endtask

    function automatic plan_t mk(int div, int bits, int intv, int dly, bit wide,
                                 bit alt, bit has, bit dbl);
        plan_t p;
        p.div = div; p.bits = bits; p.intv = intv; p.dly = dly;
        p.wide = wide; p.alt = alt; p.has = has; p.dbl = dbl;
        p.a_i = 18'($urandom); p.a_q = 18'($urandom); p.a_qn = 18'($urandom);
        p.b_i = 18'($urandom); p.b_q = 18'($urandom); p.b_qn = 18'($urandom);
        return p;
    endfunction

    function automatic plan_t rnd();
        int len = 1 + ($urandom % 18);
        int bits = ($urandom % 5 == 0) ? 17 + ($urandom % 15) : len - 1;
        bit wide = $urandom % 2;
        int dly = $urandom % 4;
        int eff = (bits + 1 > 18) ? 18 : bits + 1;
        int g = (eff + (wide ? 4 : 2) - 1) / (wide ? 4 : 2);
        int intv = dly + g + 1 + ($urandom % 6);
        if (intv < 3) intv = 3;
        return mk($urandom % 16, bits, intv, dly, wide, $urandom % 2,
                  ($urandom % 10) < 7, ($urandom % 5) == 0);
    endfunction

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        plan_t cur, nx, idle_p;
        void'($urandom(32'd4242));
        rst_n = 1'b0; vld = 1'b0; si = '0; sq = '0; sqn = '0;
        c_div = '0; c_bits = '0; c_intv = '0; c_dly = '0; c_wide = 1'b0; c_alt = 1'b0;
        repeat (4) @(negedge clk);
        chk(sclk == 0 && fsync == 0 && data == 0, "R3 reset quiet", {sclk, fsync, data}, 0);
        rst_n = 1'b1;

        // R8: the first frame has nothing pending and must be all zeros.
        cur = mk(3, 17, 12, 0, 1, 0, 0, 0);
        apply_cfg(cur);
        nx = mk(3, 17, 12, 2, 1, 0, 1, 0);                 // R4 R5 wide full length
        frame_check(cur, nx, "R8 empty first frame"); cur = nx;
        nx = mk(1, 17, 12, 1, 0, 1, 1, 0);                 // R7 neighbour Q, narrow R5
        frame_check(cur, nx, "R4 R5 wide delay 2"); cur = nx;
        nx = mk(0, 31, 10, 3, 1, 0, 1, 0);                 // R6 clamp, divide 1, delay 3
        frame_check(cur, nx, "R7 R5 narrow alt"); cur = nx;
        nx = mk(15, 0, 3, 0, 0, 0, 1, 1);                  // R9 overwrite, one-bit sample
        frame_check(cur, nx, "R6 clamp R4 delay 3"); cur = nx;
        nx = mk(2, 9, 6, 0, 1, 1, 0, 0);                   // R8 no sample
        frame_check(cur, nx, "R9 overwrite R6 one bit"); cur = nx;
        nx = rnd();
        frame_check(cur, nx, "R8 zeros R11"); cur = nx;

        for (int t = 0; t < 40; t++) begin
            nx = rnd();
            frame_check(cur, nx, "random R5 R6 R7 R11"); cur = nx;
        end

        idle_p = mk(0, 0, 0, 0, 0, 0, 0, 0);
        frame_check(cur, idle_p, "random last");
        begin
            bit quiet = 1'b1;
            int seen = 0;
            repeat (2) @(negedge clk);
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (sclk || fsync || data != 0) begin quiet = 0; seen = {sclk, fsync, data}; end
            end
            chk(quiet, "R3 stopped block quiet", seen, 0);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule